// File: doc/BRIEF.md
# Input Change-of-State Detector

This block watches a small group of general-purpose input pins and keeps a sticky record of every change of level on each of them. Every pin passes through a multi-flop synchroniser. A change of the synchronised level sets a latched delta flag for that pin. The CPU sees one status word. The upper half holds the delta flags and the lower half holds the current synchronised levels.

The bus logic around the block pulses a one-cycle read strobe when the CPU reads that status word. The strobe clears every delta flag. Because the input-change interrupt flag is taken from the latched deltas, the same read also clears that flag. A per-pin enable mask decides which deltas can raise the interrupt flag. The mask never changes the deltas themselves. If an edge is detected in the same cycle as the read, its flag is set again, so no change is lost.

Top module: `ics_detector`

## Requirements
- R1: While reset is high, and in the first cycle after it, `status_o` is all zeros and `irq_o` is low. The synchronisers and the edge history reset to level 0.
- R2: A pin value first sampled at rising edge k appears in `status_o[N_PINS-1:0]` after edge k+1. With the default of 4 pins, pin i is reported in bit i.
- R3: If the pin value sampled at edge k differs from the value sampled at edge k-1, delta bit i is set after edge k+2. Delta bit i is `status_o[N_PINS+i]`, so for the default it sits at bit 4+i.
- R4: A delta bit stays set through any later activity on its pin, including a return to the old level, until a read strobe.
- R5: When `rd_i` is high during a cycle, every delta bit is cleared at the next rising edge.
- R6: A delta bit whose edge is detected in the same cycle as a read strobe is set after that edge, not cleared.
- R7: `irq_o` is high exactly when at least one delta bit is set whose bit in `irq_en_i` (bit i for pin i) is 1. A read that clears the deltas therefore clears `irq_o` one cycle later, unless a new edge is detected in that same cycle.
- R8: `irq_en_i` has no effect on the delta bits or on the level bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pins_i | input | N_PINS | Asynchronous input pins |
| rd_i | input | 1 | One-cycle strobe: the CPU reads the status word |
| irq_en_i | input | N_PINS | Per-pin enable for the input-change interrupt |
| status_o | output | 2*N_PINS | Delta flags in the upper half, synchronised levels in the lower half |
| irq_o | output | 1 | Input-change interrupt flag |

## Verification
The bench aims a read strobe at the exact cycle in which an edge is detected. A design that clears before it merges the new edge would lose that event for good. It toggles a pin and then returns it to its old level between reads. A design that tracks the current level instead of latching would show a clear delta even though two changes happened. It drives changes with the enable mask off, then turns the mask on with the delta already pending. This shows whether the mask wrongly gates the latch, or whether the interrupt flag fails to follow a late enable. It also counts the cycles of latency against a model built from a pin history queue, so an extra or a missing synchroniser stage shows up as an error of one cycle.

// File: rtl/ics_pkg.sv
package ics_pkg;
    localparam int IC_PINS = 4;
    localparam int IC_SYNC = 2;

    // Pack deltas above levels into one status word.
    function automatic logic [2*IC_PINS-1:0] pack_status(
        input logic [IC_PINS-1:0] delta,
        input logic [IC_PINS-1:0] level
    );
        return {delta, level};
    endfunction
endpackage

// File: rtl/ics_sync.sv
module ics_sync #(
    parameter int N_PINS = 4,
    parameter int STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N_PINS-1:0] async_i,
    output logic [N_PINS-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < N_PINS; g++) begin : g_pin
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end
            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ics_edge_latch.sv
module ics_edge_latch #(
    parameter int N_PINS = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N_PINS-1:0] level_i,
    input  logic              clr_i,
    output logic [N_PINS-1:0] edge_o,
    output logic [N_PINS-1:0] delta_o
);
    logic [N_PINS-1:0] prev_q;
    logic [N_PINS-1:0] delta_q;
    logic [N_PINS-1:0] delta_d;

    assign edge_o = level_i ^ prev_q;

    // New edges win over a clear in the same cycle.
    always_comb begin
        delta_d = clr_i ? '0 : delta_q;
        delta_d = delta_d | edge_o;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q  <= '0;
            delta_q <= '0;
        end else begin
            prev_q  <= level_i;
            delta_q <= delta_d;
        end
    end

    assign delta_o = delta_q;
endmodule

// File: rtl/ics_detector.sv
module ics_detector #(
    parameter int N_PINS      = ics_pkg::IC_PINS,
    parameter int SYNC_STAGES = ics_pkg::IC_SYNC
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [N_PINS-1:0]   pins_i,
    input  logic                rd_i,
    input  logic [N_PINS-1:0]   irq_en_i,
    output logic [2*N_PINS-1:0] status_o,
    output logic                irq_o
);
    logic [N_PINS-1:0] level_vec;
    logic [N_PINS-1:0] edge_vec;
    logic [N_PINS-1:0] delta_q;

    ics_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i(pins_i),
        .sync_o (level_vec)
    );

    ics_edge_latch #(.N_PINS(N_PINS)) u_latch (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .level_i(level_vec),
        .clr_i  (rd_i),
        .edge_o (edge_vec),
        .delta_o(delta_q)
    );

    assign status_o = {delta_q, level_vec};
    assign irq_o    = |(delta_q & irq_en_i);
endmodule

// File: rtl/ics_detector_chk.sv
module ics_detector_chk #(
    parameter int N_PINS = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [N_PINS-1:0] pins_i,
    input logic              rd_i,
    input logic [N_PINS-1:0] edges,
    input logic [N_PINS-1:0] delta,
    input logic [N_PINS-1:0] level,
    input logic              irq_o
);
    logic [1:0] age_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)           age_q <= '0;
        else if (age_q != 3) age_q <= age_q + 2'd1;
    end

    // R2
    level_lat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 2) |-> (level == $past(pins_i, 2)));

    // R3
    edge_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (age_q >= 1) |-> ((delta & $past(edges)) == $past(edges)));

    // R4
    sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_i |=> ((delta & $past(delta)) == $past(delta)));

    // R5
    rd_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_i |=> (delta == $past(edges)));

    // R7
    irq_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && edges == '0) |=> !irq_o);
endmodule

bind ics_detector ics_detector_chk #(.N_PINS(N_PINS)) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .pins_i(pins_i),
    .rd_i  (rd_i),
    .edges (edge_vec),
    .delta (delta_q),
    .level (level_vec),
    .irq_o (irq_o)
);

// File: tb/ics_detector_tb.sv
module ics_detector_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pins = '0;
    logic         rd = 1'b0;
    logic [N-1:0] en = '0;
    logic [2*N-1:0] status;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ics_detector u_dut (
        .clk_i(clk), .rst_i(rst), .pins_i(pins), .rd_i(rd),
        .irq_en_i(en), .status_o(status), .irq_o(irq)
    );

    // Behavioural model: history of pin samples, newest first.
    logic [N-1:0] hist[$];
    logic [N-1:0] m_delta;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            hist = '{4'h0, 4'h0, 4'h0};
            m_delta = '0;
        end else begin
            m_delta = (rd ? '0 : m_delta) | (hist[1] ^ hist[2]);
            hist.push_front(pins);
            void'(hist.pop_back());
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        check({24'd0, status[2*N-1:N]}, {28'd0, m_delta}, "R3 R4 R5 R6 R8 delta");
        check({28'd0, status[N-1:0]}, {28'd0, hist[1]}, "R2 level");
        check({31'd0, irq}, {31'd0, |(m_delta & en)}, "R7 irq");
    endtask

    task automatic cyc(input logic [N-1:0] p, input logic r, input logic [N-1:0] m);
        @(negedge clk);
        if (!rst) compare_model();
        pins = p; rd = r; en = m;
    endtask

    initial begin
        hist = '{4'h0, 4'h0, 4'h0};
        m_delta = '0;
        repeat (3) @(negedge clk);
        check({24'd0, status}, 32'd0, "R1 status in reset");
        check({31'd0, irq}, 32'd0, "R1 irq in reset");
        rst = 1'b0;
        @(negedge clk);
        check({24'd0, status}, 32'd0, "R1 status after reset");

        // Single pin rises, mask on for that pin.
        cyc(4'b0001, 0, 4'b0001);
        repeat (4) cyc(4'b0001, 0, 4'b0001);
        check({31'd0, status[4]}, 32'd1, "R3 pin0 delta");
        check({31'd0, irq}, 32'd1, "R7 irq up");
        // Toggle back: delta stays sticky.
        repeat (5) cyc(4'b0000, 0, 4'b0001);
        check({31'd0, status[4]}, 32'd1, "R4 sticky after return");
        cyc(4'b0000, 1, 4'b0001);
        cyc(4'b0000, 0, 4'b0001);
        check({28'd0, status[7:4]}, 32'd0, "R5 cleared by read");
        check({31'd0, irq}, 32'd0, "R7 irq cleared by read");

        // Read aimed at the edge-detect cycle.
        cyc(4'b0100, 0, 4'b0000);
        cyc(4'b0100, 0, 4'b0000);
        cyc(4'b0100, 1, 4'b0000);
        cyc(4'b0100, 0, 4'b0000);
        check({31'd0, status[6]}, 32'd1, "R6 edge survives read");

        // Mask off: delta still latches, irq stays low; late enable raises it.
        cyc(4'b1100, 1, 4'b0000);
        repeat (5) cyc(4'b0110, 0, 4'b0000);
        check({28'd0, status[7:4]}, 32'b1010, "R8 delta with mask off");
        check({31'd0, irq}, 32'd0, "R8 irq masked");
        cyc(4'b0110, 0, 4'b1000);
        cyc(4'b0110, 0, 4'b1000);
        check({31'd0, irq}, 32'd1, "R7 late enable");

        // Random traffic checked against the model every cycle.
        for (int i = 0; i < 3000; i++) begin
            cyc(4'($urandom()), ($urandom() % 6) == 0, 4'($urandom()));
        end
        repeat (4) cyc(pins, 0, en);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule